// File: doc/BRIEF.md
# Wait-Mode Clock Enable Controller

This block decides which clock enables stay on while a small microcontroller is idle in its wait state. A single-cycle request puts the controller into wait. The base clock is then stopped, and so are the CPU clock and the peripheral bus clock that are derived from it. The divided peripheral clocks and the converter clock are dropped only when software has set the peripheral-stop control. The selectable divided clock is gated only when it runs from the peripheral source. The watchdog clock survives when the watchdog counts from the on-chip oscillator. The sub-clock divide-by-32 enable is never touched.

An interrupt ends the wait when its request level is strictly above the programmed resume level. The controller then issues a one-cycle wake pulse and re-asserts every enable in that same cycle. Because the comparison is strict, a resume level at the top of the range (the value software restores after each exit) leaves the part unable to wake. Every enable comes from a flop, so a downstream glitch-free gate cell can take it directly.

Top module: `wait_clkctl`

## Requirements
- R1: After reset, every clock enable output is 1, `in_wait` is 0 and `wake_pulse` is 0.
- R2: When `wait_req` is 1 at a rising clock edge while not waiting, `in_wait` becomes 1 after that edge, and `base_clk_en`, `cpu_clk_en` and `pbus_clk_en` become 0 after that same edge and stay 0 while waiting.
- R3: While waiting, `wdt_clk_en` equals the value `wdt_osc_sel` had at the previous rising edge (1 means the watchdog counts from the on-chip oscillator, so it stays enabled).
- R4: While waiting, every bit of `pdiv_clk_en` and `adc_clk_en` equals the inverse of `periph_stop` at the previous rising edge.
- R5: While waiting, `f2n_clk_en` is 1 if `f2n_src_main` was 1 at the previous rising edge (main-clock source); otherwise it is the inverse of `periph_stop` from that edge.
- R6: `fc32_clk_en` is 1 in every cycle after reset, in wait and in run.
- R7: While waiting, if `irq_valid` is 1 and `irq_lvl` > `resume_lvl` (unsigned) at a rising edge, then after that edge `wake_pulse` is 1 for exactly one cycle, `in_wait` is 0 and all enables are 1 in that same cycle.
- R8: While waiting, an interrupt with `irq_valid` 0 or with `irq_lvl` <= `resume_lvl` leaves `in_wait` at 1 and produces no wake pulse; with `resume_lvl` at its all-ones maximum, no interrupt can wake the block.
- R9: `wait_req` while already waiting has no effect, and an interrupt while running produces no wake pulse and leaves all enables at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wait_req | input | 1 | One-cycle request to enter wait |
| periph_stop | input | 1 | 1: gate the peripheral-sourced clocks during wait |
| wdt_osc_sel | input | 1 | 1: the watchdog counts from the on-chip oscillator |
| f2n_src_main | input | 1 | 1: the selectable divided clock runs from the main clock |
| resume_lvl | input | LVL_W | Resume priority level for wake-up |
| irq_valid | input | 1 | An interrupt request is pending |
| irq_lvl | input | LVL_W | Request level of the pending interrupt |
| base_clk_en | output | 1 | Base clock enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| pbus_clk_en | output | 1 | Peripheral bus clock enable |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| pdiv_clk_en | output | NUM_DIV | Divided peripheral clock enables |
| adc_clk_en | output | 1 | Converter clock enable |
| f2n_clk_en | output | 1 | Selectable divided clock enable |
| fc32_clk_en | output | 1 | Sub-clock divide-by-32 enable |
| wake_pulse | output | 1 | One-cycle wake indication |
| in_wait | output | 1 | Controller is in wait |

## Verification
The bench targets the level compare at its edges: an equal level must not wake, since a non-strict compare would exit early, and a resume level of all ones must hold the block in wait even against a maximum-level request. It also tries every combination of the peripheral-stop, watchdog-source and divided-clock-source controls during wait. A design that mixed up the source select would stop a main-sourced divided clock, or would keep the watchdog counting when it should be frozen. Repeated requests during wait and interrupts during run are mixed into the random traffic. A controller that re-entered wait or pulsed wake from run would show a spurious pulse or a dropped enable there.

// File: rtl/wait_clkctl_pkg.sv
package wait_clkctl_pkg;

   typedef enum logic {
      MODE_RUN  = 1'b0,
      MODE_WAIT = 1'b1
   } wmode_e;

   typedef struct packed {
      logic stop_periph;
      logic wdt_on_osc;
      logic f2n_on_main;
   } gate_cfg_t;

endpackage

// File: rtl/wake_cmp.sv
module wake_cmp #(
   parameter int LVL_W = 3
) (
   input  logic             req_valid,
   input  logic [LVL_W-1:0] req_lvl,
   input  logic [LVL_W-1:0] resume_lvl,
   output logic             hit
);
   if (LVL_W < 1 || LVL_W > 8) begin : g_bad_lvl
      $error("wake_cmp: LVL_W must be between 1 and 8");
   end

   // strict compare: equal levels never wake
   always_comb hit = req_valid && (req_lvl > resume_lvl);

endmodule

// File: rtl/wait_seq.sv
module wait_seq
   import wait_clkctl_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   wait_req,
   input  logic   wake_hit,
   output wmode_e mode_nxt,
   output logic   in_wait,
   output logic   wake_pulse
);
   wmode_e mode_q;
   logic   wake_q;

   always_comb begin
      mode_nxt = mode_q;
      unique case (mode_q)
         MODE_RUN:  if (wait_req) mode_nxt = MODE_WAIT;
         MODE_WAIT: if (wake_hit) mode_nxt = MODE_RUN;
         default:   mode_nxt = MODE_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RUN;
         wake_q <= 1'b0;
      end else begin
         mode_q <= mode_nxt;
         wake_q <= (mode_q == MODE_WAIT) && wake_hit;
      end
   end

   assign in_wait    = (mode_q == MODE_WAIT);
   assign wake_pulse = wake_q;

   // R7: wake pulse lasts one cycle
   a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);
   // R8: no qualifying interrupt keeps the wait
   a_r8_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (in_wait && !wake_hit) |=> in_wait);
   // R9: run is left only on request
   a_r9_run_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_wait && !wait_req) |=> !in_wait);
   // R2: entry only follows a request
   a_r2_entry_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_wait) |-> $past(wait_req));

endmodule

// File: rtl/clk_en_gate.sv
module clk_en_gate
   import wait_clkctl_pkg::*;
#(
   parameter int NUM_DIV    = 3,
   parameter bit WDT_BYPASS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               gate_on,
   input  gate_cfg_t          cfg,
   output logic               base_en,
   output logic               cpu_en,
   output logic               pbus_en,
   output logic               wdt_en,
   output logic [NUM_DIV-1:0] pdiv_en,
   output logic               adc_en,
   output logic               f2n_en,
   output logic               fc32_en
);
   if (NUM_DIV < 1 || NUM_DIV > 16) begin : g_bad_div
      $error("clk_en_gate: NUM_DIV must be between 1 and 16");
   end

   logic periph_keep;
   assign periph_keep = !(gate_on && cfg.stop_periph);

   // core clocks derived from the base clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_en <= 1'b1;
         cpu_en  <= 1'b1;
         pbus_en <= 1'b1;
      end else begin
         base_en <= !gate_on;
         cpu_en  <= !gate_on;
         pbus_en <= !gate_on;
      end
   end

   // watchdog: optional bypass when counting from the on-chip oscillator
   if (WDT_BYPASS) begin : g_wdt_bypass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) wdt_en <= 1'b1;
         else        wdt_en <= !gate_on || cfg.wdt_on_osc;
      end
   end else begin : g_wdt_gated
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) wdt_en <= 1'b1;
         else        wdt_en <= !gate_on;
      end
   end

   // divided peripheral clocks
   for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pdiv_en[i] <= 1'b1;
         else        pdiv_en[i] <= periph_keep;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adc_en  <= 1'b1;
         f2n_en  <= 1'b1;
         fc32_en <= 1'b1;
      end else begin
         adc_en  <= periph_keep;
         f2n_en  <= periph_keep || cfg.f2n_on_main;
         fc32_en <= 1'b1;
      end
   end

endmodule

// File: rtl/wait_clkctl.sv
module wait_clkctl
   import wait_clkctl_pkg::*;
#(
   parameter int LVL_W      = 3,
   parameter int NUM_DIV    = 3,
   parameter bit WDT_BYPASS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wait_req,
   input  logic               periph_stop,
   input  logic               wdt_osc_sel,
   input  logic               f2n_src_main,
   input  logic [LVL_W-1:0]   resume_lvl,
   input  logic               irq_valid,
   input  logic [LVL_W-1:0]   irq_lvl,
   output logic               base_clk_en,
   output logic               cpu_clk_en,
   output logic               pbus_clk_en,
   output logic               wdt_clk_en,
   output logic [NUM_DIV-1:0] pdiv_clk_en,
   output logic               adc_clk_en,
   output logic               f2n_clk_en,
   output logic               fc32_clk_en,
   output logic               wake_pulse,
   output logic               in_wait
);
   localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

   logic      wake_hit;
   wmode_e    mode_nxt;
   gate_cfg_t cfg;

   assign cfg = '{stop_periph: periph_stop, wdt_on_osc: wdt_osc_sel, f2n_on_main: f2n_src_main};

   wake_cmp #(.LVL_W(LVL_W)) u_cmp (
      .req_valid (irq_valid),
      .req_lvl   (irq_lvl),
      .resume_lvl(resume_lvl),
      .hit       (wake_hit)
   );

   wait_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wait_req  (wait_req),
      .wake_hit  (wake_hit),
      .mode_nxt  (mode_nxt),
      .in_wait   (in_wait),
      .wake_pulse(wake_pulse)
   );

   clk_en_gate #(.NUM_DIV(NUM_DIV), .WDT_BYPASS(WDT_BYPASS)) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .gate_on(mode_nxt == MODE_WAIT),
      .cfg    (cfg),
      .base_en(base_clk_en),
      .cpu_en (cpu_clk_en),
      .pbus_en(pbus_clk_en),
      .wdt_en (wdt_clk_en),
      .pdiv_en(pdiv_clk_en),
      .adc_en (adc_clk_en),
      .f2n_en (f2n_clk_en),
      .fc32_en(fc32_clk_en)
   );

   // R2: core clocks off throughout wait
   a_r2_core_off: assert property (@(posedge clk) disable iff (!rst_n)
      in_wait |-> (!base_clk_en && !cpu_clk_en && !pbus_clk_en));
   // R4: peripheral gating follows the stop control
   a_r4_periph_gate: assert property (@(posedge clk) disable iff (!rst_n)
      in_wait |-> (adc_clk_en == !$past(periph_stop)));
   // R5: main-sourced divided clock keeps running
   a_r5_f2n_main: assert property (@(posedge clk) disable iff (!rst_n)
      (in_wait && $past(f2n_src_main)) |-> f2n_clk_en);
   // R7: wake cycle has every enable back on
   a_r7_wake_restore: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> (!in_wait && base_clk_en && cpu_clk_en && adc_clk_en && wdt_clk_en));
   // R8: top resume level blocks every wake
   a_r8_max_level: assert property (@(posedge clk) disable iff (!rst_n)
      (in_wait && resume_lvl == LVL_MAX) |=> in_wait);

   if (WDT_BYPASS) begin : g_wdt_chk
      // R3: watchdog enable follows its source select in wait
      a_r3_wdt_src: assert property (@(posedge clk) disable iff (!rst_n)
         in_wait |-> (wdt_clk_en == $past(wdt_osc_sel)));
   end

endmodule

// File: tb/wait_clkctl_test.sv
`timescale 1ns/1ps
module wait_clkctl_test;
   localparam int LVL_W   = 3;
   localparam int NUM_DIV = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wait_req = 0, periph_stop = 0, wdt_osc_sel = 0, f2n_src_main = 0, irq_valid = 0;
   logic [LVL_W-1:0] resume_lvl = '1, irq_lvl = '0;
   logic base_clk_en, cpu_clk_en, pbus_clk_en, wdt_clk_en, adc_clk_en, f2n_clk_en, fc32_clk_en;
   logic wake_pulse, in_wait;
   logic [NUM_DIV-1:0] pdiv_clk_en;

   int n_chk = 0, n_fail = 0;
   logic m_wait = 0, m_wake = 0;
   logic e_core, e_wdt, e_per, e_f2n;

   always #5 clk = ~clk;

   wait_clkctl #(.LVL_W(LVL_W), .NUM_DIV(NUM_DIV)) uut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // expected enables from the requirements, given mode and sampled controls
   function automatic logic f_per(input logic w, input logic ps); return !(w && ps); endfunction
   function automatic logic f_f2n(input logic w, input logic ps, input logic fm);
      return fm || !(w && ps);
   endfunction

   task automatic step();
      logic ps, wo, fm;
      @(posedge clk);
      ps = periph_stop; wo = wdt_osc_sel; fm = f2n_src_main;
      m_wake = 1'b0;
      if (!m_wait) begin
         if (wait_req) m_wait = 1'b1;
      end else if (irq_valid && irq_lvl > resume_lvl) begin
         m_wait = 1'b0; m_wake = 1'b1;
      end
      e_core = !m_wait;
      e_wdt  = !m_wait || wo;
      e_per  = f_per(m_wait, ps);
      e_f2n  = f_f2n(m_wait, ps, fm);
      #1;
      chk("R2 in_wait", in_wait, m_wait);
      chk("R2 core enables", {base_clk_en, cpu_clk_en, pbus_clk_en}, {3{e_core}});
      chk("R3 wdt_clk_en", wdt_clk_en, e_wdt);
      chk("R4 div/adc enables", {pdiv_clk_en, adc_clk_en}, {(NUM_DIV+1){e_per}});
      chk("R5 f2n_clk_en", f2n_clk_en, e_f2n);
      chk("R6 fc32_clk_en", fc32_clk_en, 1'b1);
      chk("R7 wake_pulse", wake_pulse, m_wake);
   endtask

   task automatic idle_inputs();
      wait_req = 0; irq_valid = 0;
   endtask

   initial begin
      #(200000 * 10);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd20240611);
      #22;
      // R1: reset state
      chk("R1 enables", {base_clk_en, cpu_clk_en, pbus_clk_en, wdt_clk_en, pdiv_clk_en,
                         adc_clk_en, f2n_clk_en, fc32_clk_en}, {(NUM_DIV+7){1'b1}});
      chk("R1 in_wait", in_wait, 1'b0);
      chk("R1 wake_pulse", wake_pulse, 1'b0);
      rst_n = 1'b1;
      step();

      // directed: enter wait with peripherals stopped, wdt on oscillator, f2n from peripheral source
      periph_stop = 1; wdt_osc_sel = 1; f2n_src_main = 0; resume_lvl = 3'd3;
      wait_req = 1; step(); idle_inputs();
      chk("R2 directed entry", in_wait, 1'b1);
      // R9: request while waiting ignored
      wait_req = 1; step(); idle_inputs();
      // R8: equal level does not wake
      irq_valid = 1; irq_lvl = 3'd3; step(); idle_inputs();
      chk("R8 equal level", {in_wait, wake_pulse}, 2'b10);
      // R8: lower level, and valid low with a high level
      irq_valid = 1; irq_lvl = 3'd1; step();
      irq_valid = 0; irq_lvl = 3'd7; step();
      chk("R8 no valid", in_wait, 1'b1);
      // R5: switch f2n to main source while waiting
      f2n_src_main = 1; step();
      chk("R5 main source", f2n_clk_en, 1'b1);
      // R7: higher level wakes
      irq_valid = 1; irq_lvl = 3'd4; step(); idle_inputs();
      chk("R7 wake", {wake_pulse, in_wait, base_clk_en, adc_clk_en}, 4'b1011);
      step();
      chk("R7 pulse ends", wake_pulse, 1'b0);
      // R9: interrupt during run
      irq_valid = 1; irq_lvl = 3'd7; resume_lvl = 3'd0; step(); idle_inputs();
      chk("R9 irq in run", {wake_pulse, in_wait}, 2'b00);
      // R8: maximum resume level blocks wake
      resume_lvl = 3'd7; wdt_osc_sel = 0;
      wait_req = 1; step(); idle_inputs();
      irq_valid = 1; irq_lvl = 3'd7; step(); step(); idle_inputs();
      chk("R8 max resume", in_wait, 1'b1);
      chk("R3 wdt gated", wdt_clk_en, 1'b0);
      resume_lvl = 3'd6; irq_valid = 1; irq_lvl = 3'd7; step(); idle_inputs();
      chk("R7 top level wake", wake_pulse, 1'b1);

      // random traffic
      for (int i = 0; i < 3000; i++) begin
         wait_req     = ($urandom % 6) == 0;
         irq_valid    = ($urandom % 4) == 0;
         irq_lvl      = LVL_W'($urandom);
         if (($urandom % 8) == 0) resume_lvl = LVL_W'($urandom);
         periph_stop  = $urandom % 2;
         wdt_osc_sel  = $urandom % 2;
         f2n_src_main = $urandom % 2;
         step();
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule